// File: doc/BRIEF.md
# SPI Flash Write-Protection Unit

This block is the status-register and write-protection logic of a serial NOR flash device. It sits behind the serial shifter and sees each command as decoded strobes: an opcode strobe with the opcode byte, a data strobe with one byte, and an address strobe with the target address. All of these are framed by an active-low chip select. The block holds the write-enable latch, the status-register lock bit, a 4-bit block-protect value and a top/bottom select. It samples an active-low write-protect pin. For every program, sector-erase or bulk-erase request it returns a one-cycle grant or deny pulse.

The array is a power-of-two number of 64 KiB sectors (512 by default). A nonzero block-protect value `n` guards `min(2^(n-1), sectors)` sectors. These sit either at the top of the array, ending at the last sector, or at the bottom, starting at sector 0. Several commands may follow one another inside a single chip-select frame.

The command sequencer has three states. `ST_IDLE` waits for an opcode. `ST_SR_DATA` waits for the status data byte after a write-status opcode. `ST_ADDR` waits for the address after a program or sector-erase opcode. The transitions are:
- `ST_IDLE` to `ST_SR_DATA` on a write-status opcode.
- `ST_IDLE` to `ST_ADDR` on a program or sector-erase opcode.
- `ST_SR_DATA` to `ST_IDLE` on a data strobe.
- `ST_ADDR` to `ST_IDLE` on an address strobe.
- Any state to `ST_IDLE` while chip select is high (the abort transition).

Top module: `flash_wp_unit`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcodes are decoded only in `ST_IDLE` with `cs_n` low.
- R2: One cycle after opcode 0x05, `status_valid` pulses. `status_byte` always carries: bit 7 lock bit, bit 6 block-protect bit 3, bit 5 top/bottom select, bits 4:2 block-protect bits 2:0, bit 1 write-enable latch, bit 0 constant 0.
- R3: Opcode 0x01 followed by a data byte loads bits 7:2 of the byte into the same status positions. This happens when the latch is set and either `wp_n` is high or the lock bit is clear. Data bits 1:0 are ignored.
- R4: With `wp_n` low and the lock bit set, a write-status data byte is ignored and status bits 7:2 keep their old value.
- R5: A write-status (0x01), page program (0x02), sector erase (0xD8) or bulk erase (0xC7) issued with the latch clear changes no status bit. A program, sector-erase or bulk-erase request in that case returns deny.
- R6: The latch clears after every write-status data byte, every address check and every bulk erase, whether accepted or refused.
- R7: The sector index is address bits 24:16. Block-protect 0 protects nothing, and a value n>0 protects min(2^(n-1), 512) sectors. With top/bottom clear, these are the highest sectors ending at 511. With it set, they start at sector 0.
- R8: Exactly one of `grant` and `deny` pulses for one cycle, in the cycle after the address strobe. `grant` requires the latch set and the sector unprotected.
- R9: Bulk erase answers one cycle after its opcode, with grant only when the latch is set and block-protect is 0.
- R10: Raising `cs_n` returns the sequencer to `ST_IDLE` and drops a pending data or address phase. Strobes with `cs_n` high are ignored, and unrecognised opcodes change nothing.
- R11: Synchronous active-high `rst` clears the whole status register (including block-protect and top/bottom), the sequencer and all output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select framing commands |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode byte |
| data_valid | input | 1 | Data byte strobe (write-status payload) |
| data_byte | input | 8 | Data byte |
| addr_valid | input | 1 | Address strobe |
| addr | input | ADDR_W | Target byte address |
| wp_n | input | 1 | Active-low write-protect pin |
| status_byte | output | 8 | Current status byte |
| status_valid | output | 1 | Read-status response pulse |
| grant | output | 1 | Program/erase accepted pulse |
| deny | output | 1 | Program/erase refused pulse |

## Verification
On every cycle, the assertions check the following:
- the latch response to enable and disable opcodes;
- that a locked status register holds its value;
- that a request without the latch is refused;
- that the latch drops after each consuming operation;
- that grant and deny are exclusive and follow a request;
- the return to idle on chip-select release.

The geometry of the protected region is left to the bench's directed scenarios. The scenarios sweep all sixteen block-protect values with both top/bottom settings against sectors on each side of the boundary. The bench scenarios also cover the read-back layout of status bits, the bulk-erase policy and frame aborts.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_SERS = 8'hD8;
    localparam logic [7:0] OP_BERS = 8'hC7;

    localparam int SB_LOCK  = 7;
    localparam int SB_BP3   = 6;
    localparam int SB_TB    = 5;
    localparam int SB_BP_LO = 2;
    localparam int SB_WEL   = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SR_DATA = 2'd1,
        ST_ADDR    = 2'd2
    } cmd_state_t;
endpackage

// File: rtl/wpu_bp_decode.sv
module wpu_bp_decode #(
    parameter int SECTOR_BITS = 9
) (
    input  logic [3:0]             bp,
    input  logic                   tb,
    input  logic [SECTOR_BITS-1:0] sector,
    output logic                   hit
);
    localparam int CNT_W = SECTOR_BITS + 1;
    localparam logic [CNT_W-1:0] NSEC = CNT_W'(1) << SECTOR_BITS;

    logic [3:0]       shamt;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] sec_w;

    always_comb begin
        shamt = bp - 4'd1;
        if (bp == 4'd0)
            count = '0;
        else if (int'(shamt) >= SECTOR_BITS)
            count = NSEC;
        else
            count = CNT_W'(1) << shamt;
    end

    assign sec_w = {1'b0, sector};
    assign hit   = tb ? (sec_w < count) : (sec_w >= (NSEC - count));
endmodule

// File: rtl/wpu_cmd_fsm.sv
module wpu_cmd_fsm
    import wpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic       data_valid,
    input  logic       addr_valid,
    output logic       ev_wren,
    output logic       ev_wrdi,
    output logic       ev_rdsr,
    output logic       ev_bers,
    output logic       ev_sr_wr,
    output logic       ev_addr,
    output cmd_state_t state_o
);
    cmd_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst || cs_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OP_WRSR:          nxt = ST_SR_DATA;
                        OP_PROG, OP_SERS: nxt = ST_ADDR;
                        default:          nxt = ST_IDLE;
                    endcase
                end
            end
            ST_SR_DATA: if (data_valid) nxt = ST_IDLE;
            ST_ADDR:    if (addr_valid) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ev_wren  = 1'b0;
        ev_wrdi  = 1'b0;
        ev_rdsr  = 1'b0;
        ev_bers  = 1'b0;
        ev_sr_wr = 1'b0;
        ev_addr  = 1'b0;
        if (!cs_n) begin
            unique case (state)
                ST_IDLE: begin
                    ev_wren = op_valid && (op_code == OP_WREN);
                    ev_wrdi = op_valid && (op_code == OP_WRDI);
                    ev_rdsr = op_valid && (op_code == OP_RDSR);
                    ev_bers = op_valid && (op_code == OP_BERS);
                end
                ST_SR_DATA: ev_sr_wr = data_valid;
                ST_ADDR:    ev_addr  = addr_valid;
                default: ;
            endcase
        end
    end

    assign state_o = state;
endmodule

// File: rtl/wpu_status.sv
module wpu_status
    import wpu_pkg::*;
#(
    parameter int SECTOR_BITS = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wp_n,
    input  logic                   ev_wren,
    input  logic                   ev_wrdi,
    input  logic                   ev_rdsr,
    input  logic                   ev_bers,
    input  logic                   ev_sr_wr,
    input  logic                   ev_addr,
    input  logic [7:0]             data_byte,
    input  logic [SECTOR_BITS-1:0] sector,
    output logic [7:0]             status_byte,
    output logic                   status_valid,
    output logic                   grant,
    output logic                   deny
);
    logic       lock_q, tb_q, wel_q;
    logic [3:0] bp_q;
    logic       hit;
    logic       sr_locked;
    logic       addr_ok, bers_ok;

    wpu_bp_decode #(.SECTOR_BITS(SECTOR_BITS)) u_bp (
        .bp     (bp_q),
        .tb     (tb_q),
        .sector (sector),
        .hit    (hit)
    );

    assign sr_locked = !wp_n && lock_q;
    assign addr_ok   = wel_q && !hit;
    assign bers_ok   = wel_q && (bp_q == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q       <= 1'b0;
            tb_q         <= 1'b0;
            bp_q         <= '0;
            wel_q        <= 1'b0;
            status_valid <= 1'b0;
            grant        <= 1'b0;
            deny         <= 1'b0;
        end else begin
            status_valid <= ev_rdsr;
            grant        <= 1'b0;
            deny         <= 1'b0;
            if (ev_wren) wel_q <= 1'b1;
            if (ev_wrdi) wel_q <= 1'b0;
            if (ev_sr_wr) begin
                if (wel_q && !sr_locked) begin
                    lock_q <= data_byte[SB_LOCK];
                    tb_q   <= data_byte[SB_TB];
                    bp_q   <= {data_byte[SB_BP3], data_byte[SB_BP_LO+2:SB_BP_LO]};
                end
                wel_q <= 1'b0;
            end
            if (ev_addr) begin
                grant <= addr_ok;
                deny  <= !addr_ok;
                wel_q <= 1'b0;
            end
            if (ev_bers) begin
                grant <= bers_ok;
                deny  <= !bers_ok;
                wel_q <= 1'b0;
            end
        end
    end

    assign status_byte = {lock_q, bp_q[3], tb_q, bp_q[2:0], wel_q, 1'b0};
endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
    import wpu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SECTOR_LSB  = 16,
    parameter int SECTOR_BITS = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              status_valid,
    output logic              grant,
    output logic              deny
);
    localparam int SECTOR_MSB = SECTOR_LSB + SECTOR_BITS - 1;

    logic ev_wren, ev_wrdi, ev_rdsr, ev_bers, ev_sr_wr, ev_addr;
    cmd_state_t cmd_state;
    logic [SECTOR_BITS-1:0] sector;

    assign sector = addr[SECTOR_MSB:SECTOR_LSB];

    wpu_cmd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .data_valid (data_valid),
        .addr_valid (addr_valid),
        .ev_wren    (ev_wren),
        .ev_wrdi    (ev_wrdi),
        .ev_rdsr    (ev_rdsr),
        .ev_bers    (ev_bers),
        .ev_sr_wr   (ev_sr_wr),
        .ev_addr    (ev_addr),
        .state_o    (cmd_state)
    );

    wpu_status #(.SECTOR_BITS(SECTOR_BITS)) u_sr (
        .clk          (clk),
        .rst          (rst),
        .wp_n         (wp_n),
        .ev_wren      (ev_wren),
        .ev_wrdi      (ev_wrdi),
        .ev_rdsr      (ev_rdsr),
        .ev_bers      (ev_bers),
        .ev_sr_wr     (ev_sr_wr),
        .ev_addr      (ev_addr),
        .data_byte    (data_byte),
        .sector       (sector),
        .status_byte  (status_byte),
        .status_valid (status_valid),
        .grant        (grant),
        .deny         (deny)
    );
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker
    import wpu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic       wp_n,
    input logic [7:0] status_byte,
    input logic       grant,
    input logic       deny,
    input cmd_state_t cmd_state,
    input logic       ev_sr_wr,
    input logic       ev_addr,
    input logic       ev_bers
);
    p_wren_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && op_valid && op_code == OP_WREN && cmd_state == ST_IDLE) |=> status_byte[1]);

    p_wrdi_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && op_valid && op_code == OP_WRDI && cmd_state == ST_IDLE) |=> !status_byte[1]);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_sr_wr && !wp_n && status_byte[7]) |=> $stable(status_byte[7:2]));

    p_need_wel_r5: assert property (@(posedge clk) disable iff (rst)
        ((ev_addr || ev_bers) && !status_byte[1]) |=> (deny && !grant));

    p_wel_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_sr_wr || ev_addr || ev_bers) |=> !status_byte[1]);

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant, deny}));

    p_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
        (grant || deny) |-> $past(ev_addr || ev_bers));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_state == ST_IDLE));
endmodule

bind flash_wp_unit wpu_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .wp_n        (wp_n),
    .status_byte (status_byte),
    .grant       (grant),
    .deny        (deny),
    .cmd_state   (cmd_state),
    .ev_sr_wr    (ev_sr_wr),
    .ev_addr     (ev_addr),
    .ev_bers     (ev_bers)
);

// File: tb/flash_wp_unit_tb.sv
module flash_wp_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        data_valid = 1'b0;
    logic [7:0]  data_byte = 8'h00;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = 32'h0;
    logic        wp_n = 1'b1;
    logic [7:0]  status_byte;
    logic        status_valid;
    logic        grant, deny;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    flash_wp_unit u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .op_valid(op_valid), .op_code(op_code),
        .data_valid(data_valid), .data_byte(data_byte), .addr_valid(addr_valid),
        .addr(addr), .wp_n(wp_n), .status_byte(status_byte),
        .status_valid(status_valid), .grant(grant), .deny(deny)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame_on();  @(negedge clk); cs_n = 1'b0; endtask
    task automatic frame_off(); @(negedge clk); cs_n = 1'b1; endtask

    task automatic op(input logic [7:0] c);
        @(negedge clk); op_valid = 1'b1; op_code = c;
        @(negedge clk); op_valid = 1'b0;
    endtask

    task automatic dat(input logic [7:0] b);
        @(negedge clk); data_valid = 1'b1; data_byte = b;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic adr(input logic [31:0] a);
        @(negedge clk); addr_valid = 1'b1; addr = a;
        @(negedge clk); addr_valid = 1'b0;
    endtask

    task automatic read_sr(output logic [7:0] v, output logic vld);
        frame_on(); op(8'h05); vld = status_valid; v = status_byte; frame_off();
    endtask

    task automatic write_sr(input logic [7:0] b);
        frame_on(); op(8'h06); op(8'h01); dat(b); frame_off();
    endtask

    task automatic request(input logic [7:0] opc, input logic [31:0] a, output logic g, output logic d);
        frame_on(); op(8'h06); op(opc); adr(a); g = grant; d = deny; frame_off();
    endtask

    function automatic bit exp_prot(input int bp, input bit tb, input int sec);
        int cnt;
        cnt = (bp == 0) ? 0 : ((bp - 1 >= 9) ? 512 : (1 << (bp - 1)));
        return tb ? (sec < cnt) : (sec >= 512 - cnt);
    endfunction

    task automatic t_reset();
        chk(status_byte == 8'h00, "R11 reset status", status_byte, 0);
        chk({grant, deny, status_valid} == 3'b000, "R11 reset pulses", {grant, deny, status_valid}, 0);
    endtask

    task automatic t_wel();
        logic [7:0] v; logic vld;
        read_sr(v, vld);
        chk(vld == 1'b1, "R2 status_valid pulse", vld, 1);
        frame_on(); op(8'h06); frame_off();
        read_sr(v, vld);
        chk(v == 8'h02, "R1 wren sets latch", v, 8'h02);
        frame_on(); op(8'h04); frame_off();
        read_sr(v, vld);
        chk(v == 8'h00, "R1 wrdi clears latch", v, 0);
    endtask

    task automatic t_wrsr();
        logic [7:0] v; logic vld;
        write_sr(8'h5C);
        read_sr(v, vld);
        chk(v == 8'h5C, "R2 R3 status layout", v, 8'h5C);
        write_sr(8'h83);
        read_sr(v, vld);
        chk(v == 8'h80, "R3 R6 low bits ignored, latch cleared", v, 8'h80);
    endtask

    task automatic t_wp();
        logic [7:0] v; logic vld;
        write_sr(8'h00);
        read_sr(v, vld);
        chk(v == 8'h00, "R3 wp high lock set still writable", v, 0);
        wp_n = 1'b0;
        write_sr(8'h80);
        read_sr(v, vld);
        chk(v == 8'h80, "R3 wp low lock clear writable", v, 8'h80);
        write_sr(8'h1C);
        read_sr(v, vld);
        chk(v == 8'h80, "R4 R6 locked write ignored", v, 8'h80);
        wp_n = 1'b1;
        write_sr(8'h00);
        read_sr(v, vld);
        chk(v == 8'h00, "R3 unlock after wp high", v, 0);
    endtask

    task automatic t_nowel();
        logic [7:0] v; logic vld; logic g, d;
        frame_on(); op(8'h01); dat(8'h1C); frame_off();
        read_sr(v, vld);
        chk(v == 8'h00, "R5 wrsr without latch", v, 0);
        frame_on(); op(8'h02); adr(32'h0); g = grant; d = deny; frame_off();
        chk({g, d} == 2'b01, "R5 program without latch denied", {g, d}, 2'b01);
        frame_on(); op(8'hC7); g = grant; d = deny; frame_off();
        chk({g, d} == 2'b01, "R5 bulk erase without latch denied", {g, d}, 2'b01);
    endtask

    task automatic t_protect();
        logic g, d; logic [7:0] v; logic vld;
        for (int bp = 0; bp < 16; bp++) begin
            for (int tb = 0; tb < 2; tb++) begin
                int cnt;
                logic [7:0] sr;
                int secs[8];
                sr = {1'b0, 1'(bp >> 3), 1'(tb), 3'(bp), 2'b00};
                write_sr(sr);
                read_sr(v, vld);
                chk(v == sr, "R7 block-protect readback", v, sr);
                cnt = (bp == 0) ? 0 : ((bp - 1 >= 9) ? 512 : (1 << (bp - 1)));
                secs = '{0, 1, cnt - 1, cnt, 511 - cnt, 512 - cnt, 511, 255};
                for (int k = 0; k < 8; k++) begin
                    int s;
                    bit pr;
                    s = secs[k];
                    if (s < 0) s = 0;
                    if (s > 511) s = 511;
                    pr = exp_prot(bp, 1'(tb), s);
                    request((bp % 2) ? 8'hD8 : 8'h02, (32'(s) << 16) | 32'h1234, g, d);
                    chk(g == !pr && d == pr, "R7 R8 sector protection", {g, d}, {!pr, pr});
                end
            end
        end
        write_sr(8'h00);
    endtask

    task automatic t_bers();
        logic g, d; logic [7:0] v; logic vld;
        frame_on(); op(8'h06); op(8'hC7); g = grant; d = deny; frame_off();
        chk({g, d} == 2'b10, "R9 bulk erase granted bp0", {g, d}, 2'b10);
        read_sr(v, vld);
        chk(v[1] == 1'b0, "R6 latch cleared after bulk erase", v, 0);
        write_sr(8'h04);
        frame_on(); op(8'h06); op(8'hC7); g = grant; d = deny; frame_off();
        chk({g, d} == 2'b01, "R9 bulk erase denied bp1", {g, d}, 2'b01);
        write_sr(8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] v; logic vld;
        frame_on(); op(8'h06); op(8'h01); frame_off();
        frame_on(); dat(8'h1C); frame_off();
        read_sr(v, vld);
        chk(v == 8'h02, "R10 abort drops data phase", v, 8'h02);
        frame_on(); op(8'h04); frame_off();
        op(8'h06);
        read_sr(v, vld);
        chk(v == 8'h00, "R10 opcode with cs_n high ignored", v, 0);
        frame_on(); op(8'h06); op(8'hAB); frame_off();
        read_sr(v, vld);
        chk(v == 8'h02, "R10 unknown opcode ignored", v, 8'h02);
        frame_on(); op(8'h04); frame_off();
    endtask

    task automatic t_midreset();
        write_sr(8'hFC);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(status_byte == 8'h00, "R11 reset clears protect fields", status_byte, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wel();
        t_wrsr();
        t_wp();
        t_nowel();
        t_protect();
        t_bers();
        t_abort();
        t_midreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule